// File: doc/BRIEF.md
# Register-Mapped Conversion Sequencer

This block is the digital control front end of a multi-channel measurement converter. Software reaches it over a byte-wide register bus. It programs the per-conversion settings: calibration source and method, decimation select, averaging, channel and settle code. It then sets the enable and writes a conversion request.

The sequencer waits out the settle time and drives a stub converter interface, which is a one-cycle start strobe answered by a done strobe with a 16-bit code. It repeats the conversion as many times as the averaging setting asks, divides the accumulated sum by a shift, and latches the 16-bit result. It then raises end-of-conversion status and a one-cycle interrupt. The analog converter, calibration arithmetic and unit scaling lie outside the block.

Register offsets are fixed:

| Offset | Contents |
|---|---|
| 0x08 | status 1 |
| 0x09 | status 2 |
| 0x42 | parameters |
| 0x43 | averaging |
| 0x44 | channel |
| 0x45 | settle |
| 0x46 | enable |
| 0x47 | request |
| 0x50 | result low byte |
| 0x51 | result high byte |

Bus reads are combinational from `bus_addr_i`.

Top module: `meas_seq`

## Requirements
- R1: After reset, status 1 (0x08), status 2 (0x09) and both result bytes (0x50, 0x51) read 0x00, and `irq_o` and `cnv_start_o` are low.
- R2: The registers at 0x42, 0x43, 0x44, 0x45 and 0x46 read back the byte last written.
  - In 0x42, bit 6 is the calibration source (0 timer, 1 fresh), output on `cnv_cal_fresh_o`.
  - In 0x42, bits 5:4 are the calibration method (0 none, 1 ratiometric, 2 absolute), output on `cnv_cal_mode_o`.
  - `cnv_ratio_o` gives the decimation ratio from 0x42 bits 3:2: select 0 gives 256, 1 gives 512, and 2 or 3 give 1024.
  - `cnv_chan_o` mirrors 0x44.
- R3: Writing bit 7 of 0x47 while enable (bit 7 of 0x46) is set and no request is pending accepts a request. While it runs, status 1 bits 1:0 read 10b: request-pending (bit 1) is set and end-of-conversion (bit 0) is clear.
- R4: Counting the clock edge that captures the request write as edge 0, `cnv_start_o` first goes high in the cycle that follows edge settle*4+1. The settle code is bits 3:0 of 0x45, and the unit is SETTLE_UNIT=4 cycles.
- R5: With averaging enable (bit 7 of 0x43) set and code n in bits 2:0, exactly 2^n conversions run. With averaging enable clear, exactly one runs. The result is the sum of the codes shifted right by n, where n is 0 when averaging is off.
- R6: A conversion is complete only when status 1 bits 1:0 read exactly 01b. On completion the request bit (0x47 bit 7) reads 0 and `irq_o` is high for exactly one cycle per request.
- R7: The result reads as the low byte at 0x50 and the high byte at 0x51, combined as {high, low}. A read of 0x50 captures the high byte, so that a later read of 0x51 returns the high byte of the same result even after a newer completion. The result holds until the next completion.
- R8: Writing the request bit while enable is clear sets the fault flag (status 1 bit 7), starts no conversion and leaves request-pending clear. The next accepted request clears the fault flag.
- R9: A request write while a request is pending is ignored: no extra conversions run and no extra interrupt occurs.
- R10: Status 2 bits 6:4 report the sequencer step: 0 idle, 1 settling, 2 start, 3 waiting for done, 4 finishing. The finishing step is the cycle in which `irq_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (used for result snapshot) |
| bus_addr_i | input | 8 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from address |
| cnv_start_o | output | 1 | One-cycle converter start |
| cnv_done_i | input | 1 | Converter done strobe |
| cnv_code_i | input | 16 | Converter code, valid with done |
| cnv_chan_o | output | 8 | Selected channel |
| cnv_ratio_o | output | 11 | Decimation ratio in converter cycles |
| cnv_cal_mode_o | output | 2 | Calibration method |
| cnv_cal_fresh_o | output | 1 | Calibration source: 1 fresh, 0 timer |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
The hardest situation to reach from the ports is a second request that arrives while the first is still pending. It has to land inside the busy window, after acceptance and before the finishing step. The stimulus uses an averaging count of four with a converter model that answers after a fixed latency, which keeps the window wide. The bench writes the second request right after it sees the first start strobe, then counts starts and interrupts against a mark taken before the request. A similar window is opened for the result snapshot. The low byte is read, then a whole new conversion completes before the stale high byte is read.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;
  localparam logic [7:0] A_STAT1  = 8'h08;
  localparam logic [7:0] A_STAT2  = 8'h09;
  localparam logic [7:0] A_PARAM  = 8'h42;
  localparam logic [7:0] A_AVG    = 8'h43;
  localparam logic [7:0] A_CHAN   = 8'h44;
  localparam logic [7:0] A_SETTLE = 8'h45;
  localparam logic [7:0] A_EN     = 8'h46;
  localparam logic [7:0] A_REQ    = 8'h47;
  localparam logic [7:0] A_RES_LO = 8'h50;
  localparam logic [7:0] A_RES_HI = 8'h51;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_START  = 3'd2,
    ST_WAIT   = 3'd3,
    ST_DONE   = 3'd4
  } step_e;
endpackage

// File: rtl/meas_seq_regs.sv
module meas_seq_regs
  import meas_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic        bus_re_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  input  logic        fin_i,
  input  step_e       step_i,
  input  logic [15:0] result_i,
  output logic        go_o,
  output logic [7:0]  param_o,
  output logic [7:0]  avg_o,
  output logic [7:0]  chan_o,
  output logic [7:0]  settle_o
);
  logic [7:0] param_q, avg_q, chan_q, settle_q, en_q, snap_q;
  logic       req_q, eoc_q, fault_q;
  logic       req_wr;

  assign req_wr = bus_we_i && (bus_addr_i == A_REQ) && bus_wdata_i[7];
  assign go_o   = req_wr && en_q[7] && !req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      param_q  <= '0;
      avg_q    <= '0;
      chan_q   <= '0;
      settle_q <= '0;
      en_q     <= '0;
      snap_q   <= '0;
      req_q    <= 1'b0;
      eoc_q    <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      if (bus_we_i) begin
        case (bus_addr_i)
          A_PARAM:  param_q  <= bus_wdata_i;
          A_AVG:    avg_q    <= bus_wdata_i;
          A_CHAN:   chan_q   <= bus_wdata_i;
          A_SETTLE: settle_q <= bus_wdata_i;
          A_EN:     en_q     <= bus_wdata_i;
          default: ;
        endcase
      end
      if (req_wr && !en_q[7]) fault_q <= 1'b1;
      if (go_o) begin
        req_q   <= 1'b1;
        eoc_q   <= 1'b0;
        fault_q <= 1'b0;
      end else if (fin_i) begin
        req_q <= 1'b0;
        eoc_q <= 1'b1;
      end
      if (bus_re_i && (bus_addr_i == A_RES_LO)) snap_q <= result_i[15:8];
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_STAT1:  bus_rdata_o = {fault_q, 5'b0, req_q, eoc_q};
      A_STAT2:  bus_rdata_o = {1'b0, step_i, 4'b0};
      A_PARAM:  bus_rdata_o = param_q;
      A_AVG:    bus_rdata_o = avg_q;
      A_CHAN:   bus_rdata_o = chan_q;
      A_SETTLE: bus_rdata_o = settle_q;
      A_EN:     bus_rdata_o = en_q;
      A_REQ:    bus_rdata_o = {req_q, 7'b0};
      A_RES_LO: bus_rdata_o = result_i[7:0];
      A_RES_HI: bus_rdata_o = snap_q;
      default:  bus_rdata_o = 8'h00;
    endcase
  end

  assign param_o  = param_q;
  assign avg_o    = avg_q;
  assign chan_o   = chan_q;
  assign settle_o = settle_q;

  a_r3_accept_sets_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> (req_q && !eoc_q));
  a_r6_finish_sets_eoc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> (eoc_q && !req_q));
  a_r8_fault_on_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr && !en_q[7]) |=> (fault_q && !req_q));
  a_r10_idle_without_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q |-> (step_i == ST_IDLE));
endmodule

// File: rtl/meas_seq_ctrl.sv
module meas_seq_ctrl
  import meas_seq_pkg::*;
#(
  parameter int AVG_W       = 3,
  parameter int SETTLE_UNIT = 4,
  localparam int LEFT_W     = (1 << AVG_W) - 1,
  localparam int SET_W      = $clog2(15 * SETTLE_UNIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             avg_en_i,
  input  logic [AVG_W-1:0] avg_code_i,
  input  logic [3:0]       settle_i,
  output logic             cnv_start_o,
  input  logic             cnv_done_i,
  output step_e            step_o,
  output logic             acc_clr_o,
  output logic             acc_add_o,
  output logic             fin_o,
  output logic [AVG_W-1:0] shift_o
);
  step_e             state_q;
  logic [SET_W-1:0]  settle_q;
  logic [LEFT_W-1:0] left_q;
  logic [AVG_W-1:0]  shift_q;
  logic [AVG_W-1:0]  shift_n;

  assign shift_n = avg_en_i ? avg_code_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      settle_q <= '0;
      left_q   <= '0;
      shift_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (go_i) begin
          settle_q <= SET_W'(int'(settle_i) * SETTLE_UNIT);
          left_q   <= LEFT_W'((32'd1 << shift_n) - 32'd1);
          shift_q  <= shift_n;
          state_q  <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_q == '0) state_q <= ST_START;
          else settle_q <= settle_q - 1'b1;
        end
        ST_START: state_q <= ST_WAIT;
        ST_WAIT: if (cnv_done_i) begin
          if (left_q == '0) state_q <= ST_DONE;
          else begin
            left_q  <= left_q - 1'b1;
            state_q <= ST_START;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_start_o = (state_q == ST_START);
  assign acc_clr_o   = go_i && (state_q == ST_IDLE);
  assign acc_add_o   = cnv_done_i && (state_q == ST_WAIT);
  assign fin_o       = (state_q == ST_DONE);
  assign step_o      = state_q;
  assign shift_o     = shift_q;

  a_r9_accept_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (state_q == ST_IDLE));
  a_r4_start_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_start_o |=> !cnv_start_o);
endmodule

// File: rtl/meas_seq_avg.sv
module meas_seq_avg #(
  parameter int DATA_W  = 16,
  parameter int AVG_W   = 3,
  localparam int LEFT_W = (1 << AVG_W) - 1,
  localparam int SUM_W  = DATA_W + LEFT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic              fin_i,
  input  logic [AVG_W-1:0]  shift_i,
  output logic [DATA_W-1:0] result_o
);
  logic [SUM_W-1:0]  sum_q;
  logic [DATA_W-1:0] result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q    <= '0;
      result_q <= '0;
    end else begin
      if (clr_i)      sum_q <= '0;
      else if (add_i) sum_q <= sum_q + SUM_W'(code_i);
      if (fin_i)      result_q <= DATA_W'(sum_q >> shift_i);
    end
  end

  assign result_o = result_q;

  a_r7_result_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fin_i && !$past(fin_i)) |=> $stable(result_q));
endmodule

// File: rtl/meas_seq.sv
module meas_seq
  import meas_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int AVG_W       = 3,
  parameter int SETTLE_UNIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              cnv_start_o,
  input  logic              cnv_done_i,
  input  logic [DATA_W-1:0] cnv_code_i,
  output logic [7:0]        cnv_chan_o,
  output logic [10:0]       cnv_ratio_o,
  output logic [1:0]        cnv_cal_mode_o,
  output logic              cnv_cal_fresh_o,
  output logic              irq_o
);
  logic [7:0]        param, avg, chan, settle;
  logic              go, fin, acc_clr, acc_add;
  logic [AVG_W-1:0]  shift;
  logic [DATA_W-1:0] result;
  step_e             step;

  meas_seq_regs u_regs (
    .clk_i, .rst_ni, .bus_we_i, .bus_re_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .fin_i(fin), .step_i(step), .result_i(result[15:0]), .go_o(go),
    .param_o(param), .avg_o(avg), .chan_o(chan), .settle_o(settle)
  );

  meas_seq_ctrl #(.AVG_W(AVG_W), .SETTLE_UNIT(SETTLE_UNIT)) u_ctrl (
    .clk_i, .rst_ni, .go_i(go), .avg_en_i(avg[7]), .avg_code_i(avg[AVG_W-1:0]),
    .settle_i(settle[3:0]), .cnv_start_o, .cnv_done_i, .step_o(step),
    .acc_clr_o(acc_clr), .acc_add_o(acc_add), .fin_o(fin), .shift_o(shift)
  );

  meas_seq_avg #(.DATA_W(DATA_W), .AVG_W(AVG_W)) u_avg (
    .clk_i, .rst_ni, .clr_i(acc_clr), .add_i(acc_add), .code_i(cnv_code_i),
    .fin_i(fin), .shift_i(shift), .result_o(result)
  );

  always_comb begin
    case (param[3:2])
      2'd0:    cnv_ratio_o = 11'd256;
      2'd1:    cnv_ratio_o = 11'd512;
      default: cnv_ratio_o = 11'd1024;
    endcase
  end

  assign cnv_chan_o      = chan;
  assign cnv_cal_mode_o  = param[5:4];
  assign cnv_cal_fresh_o = param[6];
  assign irq_o           = fin;

  a_r6_irq_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: tb/meas_seq_tb_top.sv
module meas_seq_tb_top;
  typedef struct packed {
    logic        en;
    logic [2:0]  code;
    logic [7:0]  chan;
    logic [3:0]  settle;
    logic [15:0] base;
    logic [15:0] step;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 3'd5, 8'h11, 4'd0,  16'h1234, 16'h0000},
    '{1'b1, 3'd0, 8'h22, 4'd1,  16'hABCD, 16'h0000},
    '{1'b1, 3'd2, 8'h05, 4'd2,  16'd100,  16'd10},
    '{1'b1, 3'd3, 8'hFF, 4'd0,  16'hFFF0, 16'h0001},
    '{1'b1, 3'd7, 8'h80, 4'd15, 16'h8000, 16'h0003},
    '{1'b1, 3'd1, 8'h00, 4'd0,  16'h0007, 16'h8001}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_we_i = 1'b0, bus_re_i = 1'b0;
  logic [7:0] bus_addr_i = '0, bus_wdata_i = '0, bus_rdata_o;
  logic cnv_start_o, cnv_done_i = 1'b0, irq_o, cnv_cal_fresh_o;
  logic [15:0] cnv_code_i = '0;
  logic [7:0] cnv_chan_o;
  logic [10:0] cnv_ratio_o;
  logic [1:0] cnv_cal_mode_o;

  int checks = 0, errors = 0;
  int idx = 0, starts = 0, irqs = 0, lat = 0, mark = 0;
  logic [15:0] base = '0, step = '0;
  logic [7:0] last_chan = '0;

  always #5 clk_i = ~clk_i;

  meas_seq dut_i (.*);

  // converter model: done after fixed latency, code = base + k*step
  always @(posedge clk_i) begin
    cnv_done_i <= 1'b0;
    if (cnv_start_o) begin
      lat <= 3;
      starts <= starts + 1;
      last_chan <= cnv_chan_o;
    end else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        cnv_done_i <= 1'b1;
        cnv_code_i <= base + 16'((idx - mark) * int'(step));
        idx <= idx + 1;
      end
    end
    if (irq_o) irqs <= irqs + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_re_i = 1'b1; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_re_i = 1'b0;
  endtask

  function automatic logic [15:0] exp_avg(input logic [15:0] b, input logic [15:0] s, input int n);
    longint sum = 0;
    for (int k = 0; k < (1 << n); k++) sum += longint'(16'(b + 16'(k * int'(s))));
    return 16'(sum >> n);
  endfunction

  task automatic wait_irq(input string req);
    int t = 0;
    bus_addr_i = 8'h09;
    while (!irq_o && t < 5000) begin @(negedge clk_i); t++; end
    chk(req, int'(irq_o), 1);
    #1 chk("R10", bus_rdata_o, 8'h40);
    @(negedge clk_i);
    chk("R6", int'(irq_o), 0);
  endtask

  task automatic wait_start(output int k);
    k = 0;
    while (!cnv_start_o && k < 200) begin @(negedge clk_i); k++; end
  endtask

  logic [7:0] d, lo, hi, hi_old;
  int k, s0, i0, n;

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd(8'h08, d); chk("R1", d, 0);
    rd(8'h09, d); chk("R1", d, 0);
    rd(8'h50, d); chk("R1", d, 0);
    rd(8'h51, d); chk("R1", d, 0);
    chk("R1", {irq_o, cnv_start_o}, 0);

    // R2 readback and field decode
    wr(8'h42, 8'h14); rd(8'h42, d); chk("R2", d, 8'h14);
    chk("R2", cnv_ratio_o, 512); chk("R2", cnv_cal_mode_o, 1); chk("R2", cnv_cal_fresh_o, 0);
    wr(8'h42, 8'h6C); rd(8'h42, d); chk("R2", d, 8'h6C);
    chk("R2", cnv_ratio_o, 1024); chk("R2", cnv_cal_mode_o, 2); chk("R2", cnv_cal_fresh_o, 1);
    wr(8'h42, 8'h20); chk("R2", cnv_ratio_o, 256);
    wr(8'h45, 8'hF3); rd(8'h45, d); chk("R2", d, 8'hF3);
    wr(8'h44, 8'h5A); rd(8'h44, d); chk("R2", d, 8'h5A); chk("R2", cnv_chan_o, 8'h5A);

    // R8 request while disabled
    wr(8'h46, 8'h00);
    s0 = starts;
    wr(8'h47, 8'h80);
    repeat (20) @(negedge clk_i);
    chk("R8", starts - s0, 0);
    rd(8'h08, d); chk("R8", d, 8'h80);
    rd(8'h47, d); chk("R8", d, 8'h00);

    // vector table: R3 R4 R5 R6 R7 R10
    foreach (VEC[i]) begin
      wr(8'h43, {VEC[i].en, 4'b0, VEC[i].code});
      wr(8'h44, VEC[i].chan);
      wr(8'h45, {4'b0, VEC[i].settle});
      wr(8'h46, 8'h80);
      base = VEC[i].base; step = VEC[i].step; mark = idx;
      s0 = starts; i0 = irqs;
      n = VEC[i].en ? int'(VEC[i].code) : 0;
      wr(8'h47, 8'h80);
      wait_start(k);
      chk("R4", k, int'(VEC[i].settle) * 4 + 1);
      rd(8'h08, d); chk("R3", d, 8'h02);
      wait_irq("R6");
      rd(8'h08, d); chk("R6", d, 8'h01);
      rd(8'h47, d); chk("R6", d, 8'h00);
      rd(8'h50, lo); rd(8'h51, hi);
      chk("R5", {hi, lo}, exp_avg(VEC[i].base, VEC[i].step, n));
      chk("R5", starts - s0, 1 << n);
      chk("R2", last_chan, VEC[i].chan);
      chk("R6", irqs - i0, 1);
    end

    // R8 fault cleared by next accepted request (last row left no fault); set then clear
    wr(8'h46, 8'h00); wr(8'h47, 8'h80);
    rd(8'h08, d); chk("R8", d, 8'h81);
    wr(8'h46, 8'h80); wr(8'h43, 8'h00); wr(8'h45, 8'h00);
    base = 16'h0A0B; step = 0; mark = idx;
    wr(8'h47, 8'h80);
    wait_irq("R8");
    rd(8'h08, d); chk("R8", d, 8'h01);

    // R7 snapshot across a new completion
    rd(8'h50, lo); chk("R7", lo, 8'h0B);
    base = 16'hC3D4; mark = idx;
    wr(8'h47, 8'h80);
    wait_irq("R7");
    repeat (10) @(negedge clk_i);
    rd(8'h51, hi_old); chk("R7", hi_old, 8'h0A);
    rd(8'h50, lo); rd(8'h51, hi); chk("R7", {hi, lo}, 16'hC3D4);

    // R9 repeat request while pending
    wr(8'h43, 8'h82);
    base = 16'd40; step = 16'd4; mark = idx;
    s0 = starts; i0 = irqs;
    wr(8'h47, 8'h80);
    wait_start(k);
    wr(8'h47, 8'h80);
    rd(8'h08, d); chk("R9", d, 8'h02);
    wait_irq("R9");
    repeat (30) @(negedge clk_i);
    chk("R9", starts - s0, 4);
    chk("R9", irqs - i0, 1);
    rd(8'h50, lo); rd(8'h51, hi); chk("R9", {hi, lo}, 16'd46);

    // R10 settling and waiting steps
    wr(8'h43, 8'h00); wr(8'h45, 8'h0F);
    wr(8'h47, 8'h80);
    rd(8'h09, d); chk("R10", d, 8'h10);
    wait_start(k);
    rd(8'h09, d); chk("R10", d, 8'h30);
    wait_irq("R10");
    rd(8'h09, d); chk("R10", d, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule